// File: doc/BRIEF.md
# Three-Source Grant Arbiter with Post-DMA Rotation

This block decides which of three requesters may next drive the memory sequencer: I/O direct memory access, DRAM refresh, and the processor. Each requester raises its bit of a request vector, and the arbiter answers with a one-hot grant. The grant is issued only while the sequencer is free. It stays in place until the sequencer pulses its completion input, so the winner owns the sequencer for the whole of its flow.

Ranking is fixed in the common case: the DMA bit beats refresh, and refresh beats the processor. A long stream of DMA transfers would then shut the other two out. To prevent this, every completed DMA flow arms a one-shot rotation. The next grant decision, whoever wins it, ranks refresh highest, the processor next and DMA lowest. The rotation is then consumed. Idle cycles with no requests do not consume it.

Top module: `seq_grant_arbiter`

## Requirements
- R1: After reset, gnt_o is 0, the arbiter is free, and no rotation is armed.
- R2: gnt_o never has more than one bit set. Bit 0 is DMA, bit 1 is refresh and bit 2 is the processor, in both req_i and gnt_o.
- R3: With no rotation armed, a free arbiter that sees a nonzero req_i at a clock edge grants the highest ranked requester, in the order DMA, refresh, processor.
- R4: Completion of a DMA grant arms the rotation. The next decision then ranks refresh first, the processor second and DMA last, so a lone DMA request is still granted.
- R5: The rotation governs exactly one decision. It is disarmed by the next grant, whichever source wins.
- R6: While the arbiter is free and req_i is 0, gnt_o stays 0, and an armed rotation stays armed across any number of such cycles.
- R7: While a grant is held and done_i is low, gnt_o does not change, whatever req_i does.
- R8: done_i asserted while the arbiter is free has no effect on gnt_o or on the rotation.
- R9: Completion of a refresh or processor grant does not arm the rotation.
- R10: A grant appears on gnt_o in the cycle after the edge at which it was decided. gnt_o returns to 0 in the cycle after the edge at which done_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 3 | Requests: bit 0 DMA, bit 1 refresh, bit 2 processor |
| done_i | input | 1 | Sequencer finished the flow of the current grant |
| gnt_o | output | 3 | One-hot grant, same bit order as req_i |

## Verification
Some properties are checked on every cycle. The grant is at most one-hot. A held grant stays stable until completion and then drops on the next cycle. A free arbiter with requests always issues a grant to one of the sources that asked, and one with no requests issues none. The rotation flag sets on DMA completion, clears on a grant, and otherwise keeps its value.

Which source wins under a rotated order can only be shown by the bench scenarios. The same holds for the flag surviving idle gaps and stray completions. These scenarios run a DMA completion followed by mixed request patterns, lone DMA requests, completions of other sources and idle pulses of done_i. A behavioural model is compared against the design on every clock.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // number of request sources and the width of a source index
    localparam int unsigned N_SRC  = 3;
    localparam int unsigned SRC_W  = $clog2(N_SRC);
    // number of ranking tables (normal and rotated)
    localparam int unsigned N_RANK = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_DMA     = 2'd0,
        SRC_REFRESH = 2'd1,
        SRC_CPU     = 2'd2
    } src_e;

    typedef logic [N_SRC-1:0]                  src_vec_t;
    typedef logic [N_SRC-1:0][SRC_W-1:0]       rank_t;

    // element [0] of a rank_t is the highest ranked source
    localparam rank_t RANK_NORMAL  = '{SRC_CPU, SRC_REFRESH, SRC_DMA};
    localparam rank_t RANK_ROTATED = '{SRC_DMA, SRC_CPU, SRC_REFRESH};

    localparam int unsigned SEL_NORMAL  = 0;
    localparam int unsigned SEL_ROTATED = 1;

    localparam logic [N_RANK-1:0][N_SRC-1:0][SRC_W-1:0] RANK_TABLE =
        '{RANK_ROTATED, RANK_NORMAL};

endpackage

// File: rtl/arb_rank_pick.sv
module arb_rank_pick
    import arb_pkg::*;
#(
    parameter rank_t RANK = RANK_NORMAL
) (
    input  src_vec_t req_i,
    output src_vec_t pick_o
);

    typedef struct packed {
        src_vec_t pick;
        logic     found;
    } pick_s;

    pick_s p_d;

    always_comb begin
        p_d = '0;
        for (int r = 0; r < N_SRC; r++) begin
            if (!p_d.found && req_i[RANK[r]]) begin
                p_d.pick[RANK[r]] = 1'b1;
                p_d.found         = 1'b1;
            end
        end
    end

    assign pick_o = p_d.pick;

endmodule

// File: rtl/arb_rotate_flag.sv
module arb_rotate_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic consume_i,
    output logic armed_o
);

    typedef struct packed {
        logic armed;
    } flag_s;

    flag_s f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (arm_i) begin
            f_d.armed = 1'b1;
        end else if (consume_i) begin
            f_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign armed_o = f_q.armed;

    // arming happens only while busy, consumption only while free
    p_arm_consume_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(arm_i && consume_i));

    p_arm_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> armed_o);

    p_consume_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        consume_i |=> !armed_o);

    p_flag_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!arm_i && !consume_i) |=> $stable(armed_o));

endmodule

// File: rtl/seq_grant_arbiter.sv
module seq_grant_arbiter
    import arb_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] req_i,
    input  logic       done_i,
    output logic [2:0] gnt_o
);

    typedef struct packed {
        logic     busy;
        src_vec_t gnt;
    } arb_s;

    arb_s s_d, s_q;

    src_vec_t                picks [N_RANK];
    logic                    armed;
    logic                    issue;
    logic                    dma_done;
    src_vec_t                winner;

    // one picker per ranking table
    for (genvar g = 0; g < N_RANK; g++) begin : g_pick
        arb_rank_pick #(
            .RANK (RANK_TABLE[g])
        ) u_pick (
            .req_i  (req_i),
            .pick_o (picks[g])
        );
    end

    assign winner   = armed ? picks[SEL_ROTATED] : picks[SEL_NORMAL];
    assign issue    = !s_q.busy && (req_i != '0);
    assign dma_done = s_q.busy && done_i && s_q.gnt[SRC_DMA];

    arb_rotate_flag u_flag (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .arm_i     (dma_done),
        .consume_i (issue),
        .armed_o   (armed)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (done_i) begin
                s_d.busy = 1'b0;
                s_d.gnt  = '0;
            end
        end else if (issue) begin
            s_d.busy = 1'b1;
            s_d.gnt  = winner;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt_o = s_q.gnt;

    p_gnt_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    p_gnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o != '0 && !done_i) |=> $stable(gnt_o));

    p_gnt_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o != '0 && done_i) |=> (gnt_o == '0));

    p_gnt_issue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o == '0 && req_i != '0) |=> ((gnt_o & $past(req_i)) != '0));

    p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0));

endmodule

// File: tb/sim_seq_grant_arbiter.sv
`timescale 1ns/1ps
module sim_seq_grant_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req = '0;
    logic       done = 1'b0;
    logic [2:0] gnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    seq_grant_arbiter u0 (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .req_i  (req),
        .done_i (done),
        .gnt_o  (gnt)
    );

    // behavioural reference
    int         m_busy = 0;
    int         m_flag = 0;
    logic [2:0] m_gnt  = '0;
    int         order_n [$] = '{0, 1, 2};
    int         order_r [$] = '{1, 2, 0};

    always begin
        logic [2:0] r;
        logic       d;
        @(posedge clk);
        r = req;
        d = done;
        if (!rst_n) begin
            m_busy = 0; m_flag = 0; m_gnt = '0;
        end else if (m_busy != 0) begin
            if (d) begin
                if (m_gnt == 3'b001) m_flag = 1;
                m_gnt  = '0;
                m_busy = 0;
            end
        end else if (r != '0) begin
            int ord [$];
            ord = (m_flag != 0) ? order_r : order_n;
            foreach (ord[k]) begin
                if (r[ord[k]] && m_gnt == '0) m_gnt[ord[k]] = 1'b1;
            end
            m_flag = 0;
            m_busy = 1;
        end
        #1;
        if (rst_n && !finished) begin
            n_checks++;
            if (gnt !== m_gnt) begin
                n_fail++;
                $display("FAIL model R3 R4 R7: gnt actual=%b expected=%b at %0t", gnt, m_gnt, $time);
            end
        end
    end

    task automatic cyc(input logic [2:0] r, input logic d);
        @(negedge clk);
        req  = r;
        done = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [2:0] exp);
        n_checks++;
        if (gnt !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt actual=%b expected=%b", tag, gnt, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 normal order, R7 hold, R10 timing
        cyc(3'b111, 0); chk("R3 DMA wins", 3'b001);
        cyc(3'b100, 0); chk("R7 hold", 3'b001);
        cyc(3'b110, 0); chk("R7 hold", 3'b001);
        cyc(3'b100, 1); chk("R10 release", 3'b000);
        // R4 rotated: refresh first
        cyc(3'b111, 0); chk("R4 refresh first", 3'b010);
        cyc(3'b000, 1); chk("R10 release", 3'b000);
        // R5/R9 rotation consumed, refresh done arms nothing
        cyc(3'b111, 0); chk("R5 R9 normal again", 3'b001);
        cyc(3'b000, 1); chk("R10 release", 3'b000);
        // R6 idle keeps rotation armed
        cyc(3'b000, 0); chk("R6 idle", 3'b000);
        cyc(3'b000, 0); chk("R6 idle", 3'b000);
        cyc(3'b000, 0); chk("R6 idle", 3'b000);
        cyc(3'b101, 0); chk("R4 R6 CPU over DMA", 3'b100);
        cyc(3'b101, 1); chk("R10 release", 3'b000);
        cyc(3'b101, 0); chk("R5 consumed by CPU", 3'b001);
        cyc(3'b001, 1); chk("R10 release", 3'b000);
        // R4 lone DMA still granted while rotated
        cyc(3'b001, 0); chk("R4 lone DMA", 3'b001);
        cyc(3'b000, 1); chk("R10 release", 3'b000);
        cyc(3'b110, 0); chk("R4 refresh after DMA", 3'b010);
        cyc(3'b000, 1); chk("R10 release", 3'b000);
        // R8 idle done has no effect
        cyc(3'b000, 1); chk("R8 idle done", 3'b000);
        cyc(3'b111, 0); chk("R8 no arming", 3'b001);
        cyc(3'b000, 1); chk("R10 release", 3'b000);
        cyc(3'b000, 1); chk("R8 idle done", 3'b000);
        cyc(3'b011, 0); chk("R8 rotation kept", 3'b010);
        cyc(3'b000, 1); chk("R10 release", 3'b000);
        // R9 processor completion does not arm
        cyc(3'b100, 0); chk("R3 CPU alone", 3'b100);
        cyc(3'b000, 1); chk("R10 release", 3'b000);
        cyc(3'b101, 0); chk("R9 DMA first", 3'b001);
        cyc(3'b000, 1); chk("R10 release", 3'b000);
        cyc(3'b000, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog R10: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule